// File: doc/BRIEF.md
# Show-Cycle Bus Visibility Controller

This block sits between a processor's internal system bus and a 16-bit external bus interface and decides what the external pins show while internal bus cycles run. A 2-bit show-mode field selects the policy. With show cycles off, the external address, function code, size and read/write pins still follow internal activity, but the strobes stay inactive and the data bus is not driven. With show cycles on, each internal cycle asserts the strobes and places the internal data on the external data bus, so a logic analyser can trace internal activity.

The block also presents cycles aimed at external addresses. It holds the strobes until the external acknowledge arrives, and it stalls the internal bus while it waits. For a byte write to an external address, the written byte is copied onto both byte lanes. While an external master holds the bus grant, every pin this block drives is released. One mode also freezes the internal bus for as long as the grant is held.

Top module: `show_cycle_ctrl`

## Requirements
- R1: During reset, and after it, the address output is 0, both strobes are high (inactive), the data output enable is low and the control output enable is high.
- R2: In mode 00, an accepted internal cycle puts its address, function code, size and read/write on the external pins on the next clock, while AS and DS stay high and the data output enable stays low.
- R3: In modes 01, 10 and 11 (10 behaves as 01), an accepted internal cycle drives AS and DS low on the next clock and puts the internal data on the external data bus with the data output enable high, for reads and for writes.
- R4: The data output enable is high only while DS is low. It goes low on the clock after the last cycle completes.
- R5: A cycle aimed at an external address (ext flag 1) holds AS and DS low from the clock after it is first presented until the clock after the acknowledge. The stall output is high while the acknowledge is low. An external read leaves the data bus undriven.
- R6: Size 01 is a byte and size 10 is a word. For a byte write to an external address, the written byte is driven on both lanes: it is taken from data[15:8] when address bit 0 is 0 and from data[7:0] when it is 1.
- R7: For an internal byte cycle shown on the pins, the lane selected by address bit 0 (0 = upper) carries the internal data. The other lane is unspecified.
- R8: On the clock after the bus grant input rises, the control and data output enables go low in every mode. They recover on the clock after it falls.
- R9: In mode 11, while the grant is high, the stall output is high and no internal cycle is taken: the address pins keep their value and the strobes stay high.
- R10: In modes 00 to 10, internal cycles continue while the grant is high. The stall is low and the address pins keep following the internal bus.
- R11: A cycle aimed at an external address is stalled and not taken while the grant is high, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| mode_i | input | 2 | show-mode field |
| int_valid_i | input | 1 | internal cycle present |
| int_ext_i | input | 1 | cycle targets an external address |
| int_addr_i | input | 24 | internal address |
| int_fc_i | input | 3 | internal function code |
| int_size_i | input | 2 | cycle size (01 byte, 10 word) |
| int_rw_i | input | 1 | 1 read, 0 write |
| int_data_i | input | 16 | internal data, big-endian lanes |
| ext_bg_i | input | 1 | bus granted to an external master |
| ext_ack_i | input | 1 | external cycle acknowledge |
| int_stall_o | output | 1 | holds the internal cycle |
| ext_addr_o | output | 24 | external address |
| ext_fc_o | output | 3 | external function code |
| ext_size_o | output | 2 | external size |
| ext_rw_o | output | 1 | external read/write |
| ext_as_no | output | 1 | address strobe, active low |
| ext_ds_no | output | 1 | data strobe, active low |
| ext_ctl_oe_o | output | 1 | enable for address and control drivers |
| ext_data_o | output | 16 | external data |
| ext_data_oe_o | output | 1 | enable for data drivers |

## Verification
The hardest situation to reach is a change of grant in the middle of traffic. There, a stalled external cycle, a halted internal cycle in mode 11 and internal cycles that carry on behind released pins must each resolve on the right clock. The stimulus raises the grant while cycles are being presented in each mode and holds a cycle pending across the grant window. It then drops the grant and checks that exactly the pending cycle appears. A reference model advances once per clock, and every output is compared against it on every clock. For internal byte cycles, only the valid lane is compared.

// File: rtl/show_cycle_pkg.sv
package show_cycle_pkg;
  typedef enum logic [1:0] {
    SHOW_OFF  = 2'b00,
    SHOW_ON   = 2'b01,
    SHOW_RSVD = 2'b10,
    SHOW_HALT = 2'b11
  } show_mode_e;

  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef struct packed {
    logic show_en;
    logic halt_on_grant;
  } mode_ctl_t;
endpackage

// File: rtl/scv_mode_decode.sv
module scv_mode_decode
  import show_cycle_pkg::*;
(
  input  logic [1:0] mode_i,
  output mode_ctl_t  ctl_o
);
  show_mode_e mode;
  assign mode = show_mode_e'(mode_i);

  always_comb begin
    ctl_o = '0;
    unique case (mode)
      SHOW_OFF:  ctl_o = '{show_en: 1'b0, halt_on_grant: 1'b0};
      SHOW_ON,
      SHOW_RSVD: ctl_o = '{show_en: 1'b1, halt_on_grant: 1'b0};
      SHOW_HALT: ctl_o = '{show_en: 1'b1, halt_on_grant: 1'b1};
      default:   ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/scv_lane_mux.sv
module scv_lane_mux
  import show_cycle_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int NUM_LANES = DATA_W / 8,
  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        size_i,
  input  logic              rw_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic [DATA_W-1:0] data_o
);
  logic [7:0]        sel_byte;
  logic [DATA_W-1:0] repl;

  // lane 0 of the address is the most significant byte
  always_comb begin
    sel_byte = '0;
    for (int k = 0; k < NUM_LANES; k++)
      if (k == NUM_LANES - 1 - int'(lane_i)) sel_byte = data_i[8*k +: 8];
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_repl
    assign repl[8*g +: 8] = sel_byte;
  end

  assign data_o = (!rw_i && size_i == SZ_BYTE) ? repl : data_i;
endmodule

// File: rtl/scv_bus_gate.sv
module scv_bus_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic ext_i,
  input  logic ack_i,
  input  logic bg_i,
  input  logic halt_on_grant_i,
  output logic accept_o,
  output logic stall_o
);
  logic halt;

  assign halt     = bg_i & (halt_on_grant_i | (valid_i & ext_i));
  assign accept_o = valid_i & ~halt;
  assign stall_o  = halt | (valid_i & ext_i & ~ack_i);

  assert_halt_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bg_i && halt_on_grant_i) |-> (stall_o && !accept_o));
  assert_ext_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ext_i && !ack_i) |-> stall_o);
  assert_ext_grant_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ext_i && bg_i) |-> !accept_o);
endmodule

// File: rtl/scv_pin_stage.sv
module scv_pin_stage
  import show_cycle_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int FC_W   = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              show_en_i,
  input  logic              ext_i,
  input  logic              ack_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [FC_W-1:0]   fc_i,
  input  logic [1:0]        size_i,
  input  logic              rw_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bg_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [FC_W-1:0]   fc_o,
  output logic [1:0]        size_o,
  output logic              rw_o,
  output logic              as_no,
  output logic              ds_no,
  output logic              ctl_oe_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  logic strobe_q, oe_q, bg_q;
  logic strobe_d, oe_d;

  always_comb begin
    strobe_d = 1'b0;
    oe_d     = 1'b0;
    if (accept_i) begin
      if (ext_i) begin
        strobe_d = ~ack_i;
        oe_d     = ~ack_i & ~rw_i;
      end else begin
        strobe_d = show_en_i;
        oe_d     = show_en_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      fc_o     <= '0;
      size_o   <= '0;
      rw_o     <= 1'b1;
      data_o   <= '0;
      strobe_q <= 1'b0;
      oe_q     <= 1'b0;
      bg_q     <= 1'b0;
    end else begin
      bg_q     <= bg_i;
      strobe_q <= strobe_d;
      oe_q     <= oe_d;
      if (accept_i) begin
        addr_o <= addr_i;
        fc_o   <= fc_i;
        size_o <= size_i;
        rw_o   <= rw_i;
        data_o <= data_i;
      end
    end
  end

  assign as_no     = ~strobe_q;
  assign ds_no     = ~strobe_q;
  assign ctl_oe_o  = ~bg_q;
  assign data_oe_o = oe_q & ~bg_q;

  assert_oe_needs_ds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !ds_no);
  assert_off_no_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(accept_i && !ext_i && !show_en_i)) |-> (as_no && ds_no && !data_oe_o));
  assert_idle_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(!accept_i)) |-> (!data_oe_o && as_no));
  assert_ext_repl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && !rw_o && size_o == SZ_BYTE) |-> (data_o[15:8] == data_o[7:0]));
endmodule

// File: rtl/show_cycle_ctrl.sv
module show_cycle_ctrl
  import show_cycle_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int FC_W   = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              int_valid_i,
  input  logic              int_ext_i,
  input  logic [ADDR_W-1:0] int_addr_i,
  input  logic [FC_W-1:0]   int_fc_i,
  input  logic [1:0]        int_size_i,
  input  logic              int_rw_i,
  input  logic [DATA_W-1:0] int_data_i,
  input  logic              ext_bg_i,
  input  logic              ext_ack_i,
  output logic              int_stall_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [FC_W-1:0]   ext_fc_o,
  output logic [1:0]        ext_size_o,
  output logic              ext_rw_o,
  output logic              ext_as_no,
  output logic              ext_ds_no,
  output logic              ext_ctl_oe_o,
  output logic [DATA_W-1:0] ext_data_o,
  output logic              ext_data_oe_o
);
  localparam int NUM_LANES = DATA_W / 8;
  localparam int LANE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  mode_ctl_t         mctl;
  logic              accept;
  logic [DATA_W-1:0] lane_data;

  scv_mode_decode u_mode (
    .mode_i (mode_i),
    .ctl_o  (mctl)
  );

  scv_bus_gate u_gate (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .valid_i         (int_valid_i),
    .ext_i           (int_ext_i),
    .ack_i           (ext_ack_i),
    .bg_i            (ext_bg_i),
    .halt_on_grant_i (mctl.halt_on_grant),
    .accept_o        (accept),
    .stall_o         (int_stall_o)
  );

  scv_lane_mux #(.DATA_W(DATA_W)) u_lane (
    .data_i (int_data_i),
    .size_i (int_size_i),
    .rw_i   (int_rw_i),
    .lane_i (int_addr_i[LANE_W-1:0]),
    .data_o (lane_data)
  );

  scv_pin_stage #(.ADDR_W(ADDR_W), .FC_W(FC_W), .DATA_W(DATA_W)) u_pins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .show_en_i (mctl.show_en),
    .ext_i     (int_ext_i),
    .ack_i     (ext_ack_i),
    .addr_i    (int_addr_i),
    .fc_i      (int_fc_i),
    .size_i    (int_size_i),
    .rw_i      (int_rw_i),
    .data_i    (lane_data),
    .bg_i      (ext_bg_i),
    .addr_o    (ext_addr_o),
    .fc_o      (ext_fc_o),
    .size_o    (ext_size_o),
    .rw_o      (ext_rw_o),
    .as_no     (ext_as_no),
    .ds_no     (ext_ds_no),
    .ctl_oe_o  (ext_ctl_oe_o),
    .data_o    (ext_data_o),
    .data_oe_o (ext_data_oe_o)
  );

  assert_grant_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(ext_bg_i)) |-> (!ext_ctl_oe_o && !ext_data_oe_o));
  assert_halt_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(mode_i == 2'b11 && ext_bg_i)) |-> ($stable(ext_addr_o) && ext_as_no));
  assert_show_on_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(int_valid_i && !int_ext_i && mode_i != 2'b00 && !ext_bg_i))
      |-> (!ext_as_no && !ext_ds_no && ext_data_oe_o));
endmodule

// File: tb/tb_show_cycle_ctrl.sv
module tb_show_cycle_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [1:0]  mode;
  logic        valid, ext, rw, bg, ack;
  logic [23:0] addr;
  logic [2:0]  fc;
  logic [1:0]  size;
  logic [15:0] data;

  logic        stall_o, as_no, ds_no, ctl_oe_o, data_oe_o, rw_o;
  logic [23:0] addr_o;
  logic [2:0]  fc_o;
  logic [1:0]  size_o;
  logic [15:0] data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  show_cycle_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode),
    .int_valid_i(valid), .int_ext_i(ext), .int_addr_i(addr), .int_fc_i(fc),
    .int_size_i(size), .int_rw_i(rw), .int_data_i(data),
    .ext_bg_i(bg), .ext_ack_i(ack),
    .int_stall_o(stall_o), .ext_addr_o(addr_o), .ext_fc_o(fc_o),
    .ext_size_o(size_o), .ext_rw_o(rw_o), .ext_as_no(as_no), .ext_ds_no(ds_no),
    .ext_ctl_oe_o(ctl_oe_o), .ext_data_o(data_o), .ext_data_oe_o(data_oe_o)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // reference state
  logic [23:0] e_addr;
  logic [2:0]  e_fc;
  logic [1:0]  e_size;
  logic        e_rw, e_strobe, e_oe, e_bg;
  logic [15:0] e_data, e_mask;

  task automatic model_reset();
    e_addr = '0; e_fc = '0; e_size = '0; e_rw = 1'b1;
    e_strobe = 0; e_oe = 0; e_bg = 0; e_data = '0; e_mask = 16'hFFFF;
  endtask

  task automatic fail(string tag, string what, longint act, longint exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  task automatic compare(string tag);
    vectors++;
    if (addr_o !== e_addr) fail(tag, "addr", addr_o, e_addr);
    if (fc_o !== e_fc) fail(tag, "fc", fc_o, e_fc);
    if (size_o !== e_size) fail(tag, "size", size_o, e_size);
    if (rw_o !== e_rw) fail(tag, "rw", rw_o, e_rw);
    if (as_no !== !e_strobe) fail(tag, "as_n", as_no, !e_strobe);
    if (ds_no !== !e_strobe) fail(tag, "ds_n", ds_no, !e_strobe);
    if (ctl_oe_o !== !e_bg) fail(tag, "ctl_oe", ctl_oe_o, !e_bg);
    if (data_oe_o !== (e_oe && !e_bg)) fail(tag, "data_oe", data_oe_o, e_oe && !e_bg);
    if (e_oe && !e_bg && ((data_o & e_mask) !== (e_data & e_mask)))
      fail(tag, "data", data_o & e_mask, e_data & e_mask);
  endtask

  task automatic cyc(input logic [1:0] m, input logic v, input logic x,
                     input logic [23:0] a, input logic [1:0] s, input logic r,
                     input logic [15:0] d, input logic g, input logic k, input string tag);
    logic halt, acc, exp_stall;
    logic [7:0] b;
    mode = m; valid = v; ext = x; addr = a; fc = a[2:0] ^ 3'b101;
    size = s; rw = r; data = d; bg = g; ack = k;
    #1;
    exp_stall = (g && (m == 2'b11 || (v && x))) || (v && x && !k);
    vectors++;
    if (stall_o !== exp_stall) fail(tag, "stall", stall_o, exp_stall);
    @(posedge clk);
    halt = g && (m == 2'b11 || x);
    acc  = v && !halt;
    e_bg = g;
    if (acc) begin
      e_addr = a; e_fc = a[2:0] ^ 3'b101; e_size = s; e_rw = r;
      b = a[0] ? d[7:0] : d[15:8];
      e_data = (!r && s == 2'b01) ? {b, b} : d;
      if (x) begin
        e_strobe = !k; e_oe = !k && !r; e_mask = 16'hFFFF;
      end else begin
        e_strobe = (m != 2'b00); e_oe = e_strobe;
        e_mask = (s == 2'b01) ? (a[0] ? 16'h00FF : 16'hFF00) : 16'hFFFF;
      end
    end else begin
      e_strobe = 0; e_oe = 0;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input logic [1:0] m, input string tag);
    cyc(m, 0, 0, addr, 2'b10, 1, 16'h0, 0, 0, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; mode = 0; valid = 0; ext = 0; addr = 24'h123456; fc = 0;
    size = 2'b10; rw = 1; data = 16'hDEAD; bg = 0; ack = 0;
    model_reset();
    repeat (2) @(negedge clk);
    compare("R1");
    @(negedge clk);
    compare("R1");
    rst_ni = 1;
    idle(2'b00, "R1");

    // mode 00: pins follow, no strobes
    cyc(2'b00, 1, 0, 24'h000100, 2'b10, 1, 16'h1234, 0, 0, "R2");
    cyc(2'b00, 1, 0, 24'h000202, 2'b10, 0, 16'h5678, 0, 0, "R2");
    cyc(2'b00, 1, 0, 24'h000305, 2'b01, 0, 16'h9ABC, 0, 0, "R2");
    idle(2'b00, "R2");

    // show on, modes 01/10/11
    cyc(2'b01, 1, 0, 24'h001000, 2'b10, 0, 16'hA5C3, 0, 0, "R3");
    cyc(2'b01, 1, 0, 24'h001002, 2'b10, 1, 16'h0F1E, 0, 0, "R3");
    idle(2'b01, "R4");
    idle(2'b01, "R4");
    cyc(2'b10, 1, 0, 24'h002004, 2'b10, 1, 16'h7711, 0, 0, "R3");
    cyc(2'b11, 1, 0, 24'h002006, 2'b10, 0, 16'h3C3C, 0, 0, "R3");
    idle(2'b11, "R4");

    // internal byte show, valid lane only
    cyc(2'b01, 1, 0, 24'h003000, 2'b01, 0, 16'hAB12, 0, 0, "R7");
    cyc(2'b01, 1, 0, 24'h003001, 2'b01, 0, 16'h34CD, 0, 0, "R7");
    cyc(2'b01, 1, 0, 24'h003001, 2'b01, 1, 16'h5566, 0, 0, "R7");
    idle(2'b01, "R4");

    // external word write with two wait clocks
    cyc(2'b00, 1, 1, 24'h800000, 2'b10, 0, 16'hBEEF, 0, 0, "R5");
    cyc(2'b00, 1, 1, 24'h800000, 2'b10, 0, 16'hBEEF, 0, 0, "R5");
    cyc(2'b00, 1, 1, 24'h800000, 2'b10, 0, 16'hBEEF, 0, 1, "R5");
    idle(2'b00, "R5");
    // external read: strobes, no data drive
    cyc(2'b01, 1, 1, 24'h800010, 2'b10, 1, 16'h0000, 0, 0, "R5");
    cyc(2'b01, 1, 1, 24'h800010, 2'b10, 1, 16'h0000, 0, 1, "R5");
    // external byte writes, both lanes
    cyc(2'b00, 1, 1, 24'h800020, 2'b01, 0, 16'hC4FF, 0, 0, "R6");
    cyc(2'b00, 1, 1, 24'h800020, 2'b01, 0, 16'hC4FF, 0, 1, "R6");
    cyc(2'b01, 1, 1, 24'h800021, 2'b01, 0, 16'hFF3B, 0, 0, "R6");
    cyc(2'b01, 1, 1, 24'h800021, 2'b01, 0, 16'hFF3B, 0, 1, "R6");
    idle(2'b01, "R6");

    // grant in mode 01: pins released, internal cycles continue
    cyc(2'b01, 1, 0, 24'h004000, 2'b10, 0, 16'h1111, 1, 0, "R8");
    cyc(2'b01, 1, 0, 24'h004002, 2'b10, 1, 16'h2222, 1, 0, "R10");
    cyc(2'b00, 1, 0, 24'h004004, 2'b10, 1, 16'h3333, 1, 0, "R10");
    cyc(2'b10, 1, 0, 24'h004006, 2'b10, 0, 16'h4444, 0, 0, "R8");
    idle(2'b10, "R8");

    // mode 11 halt under grant, then release with pending cycle
    cyc(2'b11, 1, 0, 24'h005000, 2'b10, 0, 16'h5151, 1, 0, "R9");
    cyc(2'b11, 1, 0, 24'h005000, 2'b10, 0, 16'h5151, 1, 0, "R9");
    cyc(2'b11, 0, 0, 24'h005000, 2'b10, 0, 16'h5151, 1, 0, "R9");
    cyc(2'b11, 1, 0, 24'h005000, 2'b10, 0, 16'h5151, 0, 0, "R9");
    idle(2'b11, "R9");

    // external cycle held across a grant window
    cyc(2'b01, 1, 1, 24'h806000, 2'b10, 0, 16'h6161, 1, 0, "R11");
    cyc(2'b00, 1, 1, 24'h806000, 2'b10, 0, 16'h6161, 1, 1, "R11");
    cyc(2'b00, 1, 1, 24'h806000, 2'b10, 0, 16'h6161, 0, 0, "R11");
    cyc(2'b00, 1, 1, 24'h806000, 2'b10, 0, 16'h6161, 0, 1, "R11");
    idle(2'b00, "R5");

    // reset again mid-traffic
    cyc(2'b01, 1, 0, 24'h007000, 2'b10, 0, 16'h7070, 0, 0, "R3");
    rst_ni = 0;
    model_reset();
    #1;
    compare("R1");
    @(negedge clk);
    rst_ni = 1;
    idle(2'b00, "R1");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule